// File: doc/BRIEF.md
# Relocatable Tightly Coupled SRAM

This block is a small on-chip memory placed next to the processor. A single control register sets where it sits in the 32-bit address space: it can start at any 4 KB-aligned address. It also holds an enable flag and a flag that ties the memory to either the instruction-fetch port or the data port. Each request is checked against the programmed base in the cycle it arrives. A hit is served from the local array, and a new request can be accepted every cycle. Read data is returned one cycle after the request.

For every request the block also reports a routing target. A request that falls in the local region goes to the local SRAM. Otherwise it goes to the cache when the request is marked cacheable, and to the external path when it is not. The local region is never cached. A fetch that hits the local region tells the cache to throw away whatever it would have returned. A data hit leaves the cache alone.

The core can only write the control register. A debug agent can both write it and read it back. Debug memory references are presented on the data port, so they behave as data-side accesses. Reset clears only the enable flag. The base and the port-binding flag keep their values through reset.

Top module: `reloc_lmem`

## Requirements
- R1: A request hits when all of these are true: the enable flag is set, the request is on the bound port, address bits [31:12] equal the programmed base, and the offset lies inside the array (`WORDS*4` bytes; 0x000 to 0x3FF for the default 256 words).
- R2: Reset clears the enable flag, so no request hits. The base field and the binding flag keep their previous values, and debug read-back shows them.
- R3: The register layout is: bit 0 = enable, bit 1 = binding (1 = data port, 0 = instruction port), bits [31:12] = base. Bits [11:2] are discarded on write and always read back as zero.
- R4: The core writes the register through `cfg_wr`. The debug agent writes it through `dbg_reg_wr` and reads it at any time on `dbg_reg_rdata`. When both write in the same cycle, the debug value is stored.
- R5: A request on the port that is not bound never hits and never raises an error. Its target is resolved as if it lay outside the region.
- R6: Data accesses take `d_size` 00 = byte, 01 = 16-bit word, 10 = 32-bit longword. Byte lanes are big-endian: byte offset 0 is bits [31:24] of the stored word. Write data is taken from the low bits of `d_wdata`. Read data is returned right-justified and zero-extended on `rd_data`. Fetches always read a whole word.
- R7: A request inside the region raises its error flag instead of hitting, and does not change the memory, in any of these cases: a word access with address bit 0 set, a longword access or fetch with address bits [1:0] not zero, or `d_size` = 11. Misaligned requests outside the region raise no error.
- R8: The target code is 00 (local) for any request in the region on the bound port, including misaligned ones. Otherwise it is 01 (cache) when the cacheable input is set, and 10 (external) when it is not.
- R9: `if_discard` is high in the same cycle as an instruction-fetch hit. A data hit never raises it.
- R10: After a read hit, `rd_valid` is high with the data on the following cycle. Reads can follow each other every cycle. A write followed on the next cycle by a read of the same location returns the newly written data.
- R11: A register write changes decoding from the next cycle on. A request in the same cycle as the write is decoded with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Core write strobe for the control register |
| cfg_wdata | input | 32 | Core write value |
| dbg_reg_wr | input | 1 | Debug write strobe for the control register |
| dbg_reg_wdata | input | 32 | Debug write value |
| dbg_reg_rdata | output | 32 | Debug read-back of the control register |
| if_req | input | 1 | Instruction-fetch request |
| if_addr | input | 32 | Fetch byte address |
| if_cacheable | input | 1 | Fetch region is cacheable |
| if_hit | output | 1 | Fetch served locally |
| if_err | output | 1 | Misaligned fetch in the region |
| if_target | output | 2 | Fetch routing target |
| if_discard | output | 1 | Cache must drop its fetch data |
| d_req | input | 1 | Data request (core or debug) |
| d_we | input | 1 | Data write |
| d_size | input | 2 | Access size |
| d_addr | input | 32 | Data byte address |
| d_wdata | input | 32 | Right-justified write data |
| d_cacheable | input | 1 | Data region is cacheable |
| d_hit | output | 1 | Data request served locally |
| d_err | output | 1 | Misaligned or bad-size data access in the region |
| d_target | output | 2 | Data routing target |
| rd_valid | output | 1 | Read data valid (one cycle after a read hit) |
| rd_data | output | 32 | Right-justified read data |

## Verification
Two functions can fall in the same cycle.

The first pair is a register write and a memory request. The bench raises a base change together with a data read aimed at the new base. It expects a miss routed to the external path in that cycle, then a hit when the same request is held for one more cycle.

The second pair is a write and the next read. A write immediately followed by a read of the same location must return the new bytes. The vector table pairs writes and reads on adjacent cycles to check this. A fetch and a data request issued together check that only the bound side answers.

// File: rtl/reloc_lmem_pkg.sv
package reloc_lmem_pkg;

  typedef enum logic [1:0] {
    TGT_LOCAL = 2'b00,
    TGT_CACHE = 2'b01,
    TGT_EXT   = 2'b10
  } tgt_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  localparam int BASE_W    = 20;
  localparam int BASE_LSB  = 12;
  localparam logic [31:0] REG_KEEP = 32'hFFFF_F003;

  // true when the access cannot be performed at this offset/size
  function automatic logic bad_align(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: bad_align = 1'b0;
      SZ_WORD: bad_align = off[0];
      SZ_LONG: bad_align = (off != 2'b00);
      default: bad_align = 1'b1;
    endcase
  endfunction

  // byte enables, bit 3 = lane [31:24] = byte offset 0
  function automatic logic [3:0] lane_en(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: lane_en = 4'b1000 >> off;
      SZ_WORD: lane_en = off[1] ? 4'b0011 : 4'b1100;
      default: lane_en = 4'b1111;
    endcase
  endfunction

  // move right-justified write data into its big-endian lanes
  function automatic logic [31:0] lane_place(input logic [1:0] sz, input logic [1:0] off,
                                             input logic [31:0] wd);
    case (sz)
      SZ_BYTE: begin
        case (off)
          2'd0:    lane_place = {wd[7:0], 24'h0};
          2'd1:    lane_place = {8'h0, wd[7:0], 16'h0};
          2'd2:    lane_place = {16'h0, wd[7:0], 8'h0};
          default: lane_place = {24'h0, wd[7:0]};
        endcase
      end
      SZ_WORD: lane_place = off[1] ? {16'h0, wd[15:0]} : {wd[15:0], 16'h0};
      default: lane_place = wd;
    endcase
  endfunction

  // extract the addressed lanes, right-justified and zero-extended
  function automatic logic [31:0] lane_pick(input logic [1:0] sz, input logic [1:0] off,
                                            input logic [31:0] word);
    case (sz)
      SZ_BYTE: begin
        case (off)
          2'd0:    lane_pick = {24'h0, word[31:24]};
          2'd1:    lane_pick = {24'h0, word[23:16]};
          2'd2:    lane_pick = {24'h0, word[15:8]};
          default: lane_pick = {24'h0, word[7:0]};
        endcase
      end
      SZ_WORD: lane_pick = off[1] ? {16'h0, word[15:0]} : {16'h0, word[31:16]};
      default: lane_pick = word;
    endcase
  endfunction

endpackage

// File: rtl/reloc_lmem_basereg.sv
module reloc_lmem_basereg
  import reloc_lmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_we,
  input  logic [31:0]       core_wdata,
  input  logic              dbg_we,
  input  logic [31:0]       dbg_wdata,
  output logic [BASE_W-1:0] base,
  output logic              bind_data,
  output logic              enabled,
  output logic [31:0]       rd_view
);

  logic              wr_any;
  logic [31:0]       wsel;
  logic              en_q;
  logic              bind_q;
  logic [BASE_W-1:0] base_q;
  logic              unused_rsv;

  assign wr_any     = core_we | dbg_we;
  assign wsel       = dbg_we ? dbg_wdata : core_wdata;
  assign unused_rsv = ^wsel[BASE_LSB-1:2];

  // only the enable flag is reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (wr_any) en_q <= wsel[0];
  end

  always_ff @(posedge clk) begin
    if (wr_any) begin
      base_q <= wsel[31:BASE_LSB];
      bind_q <= wsel[1];
    end
  end

  assign base      = base_q;
  assign bind_data = bind_q;
  assign enabled   = en_q;
  assign rd_view   = {base_q, 10'h0, bind_q, en_q};

  // R4: the debug write wins a same-cycle collision
  p_dbg_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && core_we) |=> (rd_view == ($past(dbg_wdata) & REG_KEEP)));

  // R11: without a write the register image does not move
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_we && !dbg_we) |=> $stable(rd_view));

endmodule

// File: rtl/reloc_lmem_decode.sv
module reloc_lmem_decode
  import reloc_lmem_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [31:0]       addr,
  input  logic [1:0]        size,
  input  logic              cacheable,
  input  logic [BASE_W-1:0] base,
  input  logic              enabled,
  input  logic              bound,
  output logic              hit,
  output logic              err,
  output logic [1:0]        target,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        off
);

  localparam int TOP_OFF = IDX_W + 2;

  logic beyond;
  logic in_region;
  logic misal;
  tgt_e tgt;

  generate
    if (TOP_OFF < BASE_LSB) begin : g_partial
      assign beyond = |addr[BASE_LSB-1:TOP_OFF];
    end else begin : g_full
      assign beyond = 1'b0;
    end
  endgenerate

  assign in_region = enabled && bound && (addr[31:BASE_LSB] == base) && !beyond;
  assign misal     = bad_align(size, addr[1:0]);
  assign hit       = req && in_region && !misal;
  assign err       = req && in_region && misal;
  assign idx       = addr[TOP_OFF-1:2];
  assign off       = addr[1:0];

  always_comb begin
    if (in_region)      tgt = TGT_LOCAL;
    else if (cacheable) tgt = TGT_CACHE;
    else                tgt = TGT_EXT;
  end
  assign target = tgt;

  // R5: an unbound side stays silent
  p_unbound_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bound |-> (!hit && !err && target != TGT_LOCAL));

  // R1: without the enable flag nothing is served
  p_disabled_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !hit);

endmodule

// File: rtl/reloc_lmem_array.sv
module reloc_lmem_array #(
  parameter int WORDS = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       be,
  input  logic [31:0]      wword,
  output logic [31:0]      rword
);

  logic [31:0] mem [WORDS];
  logic [31:0] rword_q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int l = 0; l < 4; l++) begin
        if (be[l]) mem[idx][8*l +: 8] <= wword[8*l +: 8];
      end
    end
    if (en && !we) rword_q <= mem[idx];
  end

  assign rword = rword_q;

  // R10: a full-word write is seen by a read of the same word on the next cycle
  p_wr_then_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we && be == 4'hF) ##1 (en && !we && idx == $past(idx))
      |=> (rword == $past(wword, 2)));

endmodule

// File: rtl/reloc_lmem.sv
module reloc_lmem
  import reloc_lmem_pkg::*;
#(
  parameter int WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        dbg_reg_wr,
  input  logic [31:0] dbg_reg_wdata,
  output logic [31:0] dbg_reg_rdata,
  input  logic        if_req,
  input  logic [31:0] if_addr,
  input  logic        if_cacheable,
  output logic        if_hit,
  output logic        if_err,
  output logic [1:0]  if_target,
  output logic        if_discard,
  input  logic        d_req,
  input  logic        d_we,
  input  logic [1:0]  d_size,
  input  logic [31:0] d_addr,
  input  logic [31:0] d_wdata,
  input  logic        d_cacheable,
  output logic        d_hit,
  output logic        d_err,
  output logic [1:0]  d_target,
  output logic        rd_valid,
  output logic [31:0] rd_data
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [BASE_W-1:0] base;
  logic              bind_data;
  logic              enabled;

  logic [IDX_W-1:0]  i_idx, d_idx;
  logic [1:0]        i_off, d_off;

  logic              acc_en, acc_we;
  logic [IDX_W-1:0]  acc_idx;
  logic [1:0]        acc_sz, acc_off;
  logic [3:0]        acc_be;
  logic [31:0]       acc_wword;
  logic [31:0]       rword;

  logic              rdv_q;
  logic [1:0]        sz_q, off_q;

  reloc_lmem_basereg u_reg (
    .clk(clk), .rst_n(rst_n),
    .core_we(cfg_wr), .core_wdata(cfg_wdata),
    .dbg_we(dbg_reg_wr), .dbg_wdata(dbg_reg_wdata),
    .base(base), .bind_data(bind_data), .enabled(enabled),
    .rd_view(dbg_reg_rdata)
  );

  reloc_lmem_decode #(.IDX_W(IDX_W)) u_dec_if (
    .clk(clk), .rst_n(rst_n),
    .req(if_req), .addr(if_addr), .size(SZ_LONG), .cacheable(if_cacheable),
    .base(base), .enabled(enabled), .bound(!bind_data),
    .hit(if_hit), .err(if_err), .target(if_target),
    .idx(i_idx), .off(i_off)
  );

  reloc_lmem_decode #(.IDX_W(IDX_W)) u_dec_d (
    .clk(clk), .rst_n(rst_n),
    .req(d_req), .addr(d_addr), .size(d_size), .cacheable(d_cacheable),
    .base(base), .enabled(enabled), .bound(bind_data),
    .hit(d_hit), .err(d_err), .target(d_target),
    .idx(d_idx), .off(d_off)
  );

  // the bound side owns the array
  assign acc_en    = bind_data ? d_hit : if_hit;
  assign acc_we    = bind_data && d_we;
  assign acc_idx   = bind_data ? d_idx : i_idx;
  assign acc_sz    = bind_data ? d_size : SZ_LONG;
  assign acc_off   = bind_data ? d_off : i_off;
  assign acc_be    = lane_en(acc_sz, acc_off);
  assign acc_wword = lane_place(acc_sz, acc_off, d_wdata);

  reloc_lmem_array #(.WORDS(WORDS), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .en(acc_en), .we(acc_we), .idx(acc_idx),
    .be(acc_be), .wword(acc_wword), .rword(rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdv_q <= 1'b0;
    else        rdv_q <= acc_en && !acc_we;
  end

  always_ff @(posedge clk) begin
    if (acc_en && !acc_we) begin
      sz_q  <= acc_sz;
      off_q <= acc_off;
    end
  end

  assign rd_valid   = rdv_q;
  assign rd_data    = lane_pick(sz_q, off_q, rword);
  assign if_discard = if_hit;

  // R5: only one side can be served
  p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_hit && d_hit));

  // R7: an error never coexists with a hit on the data side
  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_hit && d_err));

  // R8: served or faulted data requests route locally
  p_local_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (d_hit || d_err) |-> (d_target == TGT_LOCAL));

  // R9: a data hit never tells the cache to discard
  p_no_discard_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    d_hit |-> !if_discard);

  // R10: read hits return data on the next cycle
  p_read_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (d_hit && !d_we) |=> rd_valid);

endmodule

// File: tb/reloc_lmem_test.sv
module reloc_lmem_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        dbg_reg_wr = 1'b0;
  logic [31:0] dbg_reg_wdata = '0;
  logic [31:0] dbg_reg_rdata;
  logic        if_req = 1'b0;
  logic [31:0] if_addr = '0;
  logic        if_cacheable = 1'b0;
  logic        if_hit, if_err, if_discard;
  logic [1:0]  if_target;
  logic        d_req = 1'b0;
  logic        d_we = 1'b0;
  logic [1:0]  d_size = '0;
  logic [31:0] d_addr = '0;
  logic [31:0] d_wdata = '0;
  logic        d_cacheable = 1'b0;
  logic        d_hit, d_err;
  logic [1:0]  d_target;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  reloc_lmem uut (.*);

  typedef struct packed {
    logic        side;   // 1 data, 0 fetch
    logic        we;
    logic [1:0]  size;
    logic        cach;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        hit;
    logic        err;
    logic [1:0]  tgt;
    logic        disc;
    logic        rdv;
    logic [31:0] rdata;
  } vec_t;

  // base 0x20003000 bound to data; region 0x20003000..0x200033FF
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,2'd2,1'b0,32'h20003000,32'hA1B2C3D4,1'b1,1'b0,2'd0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,2'd2,1'b0,32'h20003000,32'h0,       1'b1,1'b0,2'd0,1'b0,1'b1,32'hA1B2C3D4},
    '{1'b1,1'b1,2'd0,1'b0,32'h20003001,32'h000000EE,1'b1,1'b0,2'd0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,2'd1,1'b0,32'h20003002,32'h0,       1'b1,1'b0,2'd0,1'b0,1'b1,32'h0000C3D4},
    '{1'b1,1'b0,2'd0,1'b0,32'h20003001,32'h0,       1'b1,1'b0,2'd0,1'b0,1'b1,32'h000000EE},
    '{1'b1,1'b1,2'd1,1'b0,32'h20003006,32'h00001234,1'b1,1'b0,2'd0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,2'd1,1'b0,32'h20003006,32'h0,       1'b1,1'b0,2'd0,1'b0,1'b1,32'h00001234},
    '{1'b1,1'b0,2'd0,1'b0,32'h20003000,32'h0,       1'b1,1'b0,2'd0,1'b0,1'b1,32'h000000A1},
    '{1'b1,1'b0,2'd1,1'b0,32'h20003001,32'h0,       1'b0,1'b1,2'd0,1'b0,1'b0,32'h0},
    '{1'b1,1'b1,2'd2,1'b0,32'h20003002,32'hFFFFFFFF,1'b0,1'b1,2'd0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,2'd3,1'b0,32'h20003000,32'h0,       1'b0,1'b1,2'd0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,2'd2,1'b0,32'h20003000,32'h0,       1'b1,1'b0,2'd0,1'b0,1'b1,32'hA1EEC3D4},
    '{1'b1,1'b1,2'd2,1'b0,32'h200033FC,32'h0BADF00D,1'b1,1'b0,2'd0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,2'd2,1'b0,32'h200033FC,32'h0,       1'b1,1'b0,2'd0,1'b0,1'b1,32'h0BADF00D},
    '{1'b1,1'b0,2'd2,1'b1,32'h20003400,32'h0,       1'b0,1'b0,2'd1,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,2'd2,1'b0,32'h20004000,32'h0,       1'b0,1'b0,2'd2,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,2'd1,1'b0,32'h20005001,32'h0,       1'b0,1'b0,2'd2,1'b0,1'b0,32'h0},
    '{1'b0,1'b0,2'd2,1'b1,32'h20003000,32'h0,       1'b0,1'b0,2'd1,1'b0,1'b0,32'h0},
    '{1'b0,1'b0,2'd2,1'b0,32'h20003000,32'h0,       1'b0,1'b0,2'd2,1'b0,1'b0,32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    if_req = 1'b0; d_req = 1'b0; d_we = 1'b0;
    cfg_wr = 1'b0; dbg_reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R2 reset state
    check("R2 enable cleared by reset", {31'h0, dbg_reg_rdata[0]}, 32'h0);
    d_req = 1'b1; d_addr = 32'h0; d_size = 2'd2;
    #1 check("R2 no hit after reset", {31'h0, d_hit}, 32'h0);

    // R3/R4 core write with reserved bits set
    @(negedge clk) idle(); cfg_wr = 1'b1; cfg_wdata = 32'h20003FF3;
    @(negedge clk) cfg_wr = 1'b0;
    #1 check("R3 reserved bits read zero, R4 core write", dbg_reg_rdata, 32'h20003003);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      if (VEC[i].side) begin
        d_req = 1'b1; d_we = VEC[i].we; d_size = VEC[i].size;
        d_addr = VEC[i].addr; d_wdata = VEC[i].wdata; d_cacheable = VEC[i].cach;
      end else begin
        if_req = 1'b1; if_addr = VEC[i].addr; if_cacheable = VEC[i].cach;
      end
      #1;
      if (VEC[i].side) begin
        check($sformatf("R1 data hit v%0d", i), {31'h0, d_hit}, {31'h0, VEC[i].hit});
        check($sformatf("R7 data err v%0d", i), {31'h0, d_err}, {31'h0, VEC[i].err});
        check($sformatf("R8 data target v%0d", i), {30'h0, d_target}, {30'h0, VEC[i].tgt});
      end else begin
        check($sformatf("R5 fetch hit v%0d", i), {31'h0, if_hit}, {31'h0, VEC[i].hit});
        check($sformatf("R7 fetch err v%0d", i), {31'h0, if_err}, {31'h0, VEC[i].err});
        check($sformatf("R8 fetch target v%0d", i), {30'h0, if_target}, {30'h0, VEC[i].tgt});
      end
      check($sformatf("R9 discard v%0d", i), {31'h0, if_discard}, {31'h0, VEC[i].disc});
      @(posedge clk);
      #1;
      check($sformatf("R10 rd_valid v%0d", i), {31'h0, rd_valid}, {31'h0, VEC[i].rdv});
      if (VEC[i].rdv)
        check($sformatf("R6/R10 rd_data v%0d", i), rd_data, VEC[i].rdata);
    end

    // R11: register write and request in the same cycle
    @(negedge clk) idle();
    cfg_wr = 1'b1; cfg_wdata = 32'h40000003;
    d_req = 1'b1; d_we = 1'b0; d_size = 2'd2; d_addr = 32'h40000000; d_cacheable = 1'b0;
    #1 check("R11 old base used in write cycle", {31'h0, d_hit}, 32'h0);
    check("R11 old base routes external", {30'h0, d_target}, 32'h2);
    @(negedge clk) cfg_wr = 1'b0;
    #1 check("R11 new base active next cycle", {31'h0, d_hit}, 32'h1);
    @(posedge clk); #1;
    check("R1 relocated read returns word 0", rd_data, 32'hA1EEC3D4);

    // R4: debug write wins over core write
    @(negedge clk) idle();
    cfg_wr = 1'b1; cfg_wdata = 32'h40000003;
    dbg_reg_wr = 1'b1; dbg_reg_wdata = 32'h40000FF1;
    @(negedge clk) idle();
    #1 check("R4 debug write wins collision", dbg_reg_rdata, 32'h40000001);

    // bound to instruction side now: fetch hits, data misses
    @(negedge clk) idle();
    if_req = 1'b1; if_addr = 32'h40000000; if_cacheable = 1'b1;
    d_req = 1'b1; d_we = 1'b0; d_size = 2'd2; d_addr = 32'h40000000; d_cacheable = 1'b0;
    #1 check("R9 fetch hit", {31'h0, if_hit}, 32'h1);
    check("R9 discard on fetch hit", {31'h0, if_discard}, 32'h1);
    check("R8 fetch hit target local", {30'h0, if_target}, 32'h0);
    check("R5 data side unbound misses", {31'h0, d_hit}, 32'h0);
    check("R5 unbound data routes external", {30'h0, d_target}, 32'h2);
    @(posedge clk); #1;
    check("R10 fetch data next cycle", rd_data, 32'hA1EEC3D4);
    check("R10 fetch rd_valid", {31'h0, rd_valid}, 32'h1);

    @(negedge clk) idle();
    if_req = 1'b1; if_addr = 32'h40000002;
    #1 check("R7 misaligned fetch err", {31'h0, if_err}, 32'h1);
    check("R7 misaligned fetch no hit", {31'h0, if_hit}, 32'h0);

    // R2: reset keeps base and binding, clears enable
    @(negedge clk) idle(); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R2 base and bind kept through reset", dbg_reg_rdata, 32'h40000000);
    if_req = 1'b1; if_addr = 32'h40000000; if_cacheable = 1'b0;
    #1 check("R2 no fetch hit after reset", {31'h0, if_hit}, 32'h0);
    check("R2 disabled fetch routes external", {30'h0, if_target}, 32'h2);

    @(negedge clk) idle();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

endmodule